// File: doc/BRIEF.md
# Descriptor-Chain Transmit DMA Engine

The engine moves outgoing frames from memory to a byte-wide transmit stream. Software builds a linked chain of four-word descriptors in memory. Each descriptor gives a control/status word, a length word, a buffer byte address and the byte address of the next descriptor. Software writes the chain's head address into the engine's pointer register and then issues a go command. The engine walks the chain. For every descriptor it owns, it reads the buffer one 32-bit word at a time and presents the bytes on a valid/ready stream. It then waits for the MAC side to report whether the attempt succeeded. Finally it writes the status word back with the ownership flag cleared, which returns the descriptor to software.

A failed attempt resends the whole frame, up to a fixed number of retries. After the last retry fails, the descriptor is closed with an error code. The engine also pads short frames with zero bytes when the descriptor asks for it. It pulses a completion strobe for every closed descriptor, plus an interrupt strobe when the descriptor requests one. A halt command aborts any activity at once.

The controller is one state machine with these states:
- IDLE: waiting for a go command.
- GET_CMD, GET_LEN, GET_BUF, GET_NEXT: the four descriptor reads.
- SEND: presenting bytes.
- LOAD: reading the next buffer word.
- WAIT_MAC: waiting for the attempt result.
- WRITE_BACK: storing the status word.

The transitions are:
- IDLE goes to GET_CMD on go.
- GET_CMD goes back to IDLE if the descriptor is not owned, and otherwise to GET_LEN.
- GET_LEN goes to GET_BUF, and GET_BUF goes to GET_NEXT.
- GET_NEXT goes to SEND. It goes straight to WRITE_BACK when the frame has zero bytes.
- SEND goes to LOAD when the buffer word it needs is not yet held, and to WAIT_MAC after the final byte.
- LOAD goes back to SEND.
- WAIT_MAC goes back to SEND when a retry is due, and to WRITE_BACK on success or when retries are exhausted.
- WRITE_BACK goes to GET_CMD when the next pointer is non-zero, and otherwise to IDLE.
- A halt command forces IDLE from every state.

Top module: `tdma_tx_engine`

## Requirements
- R1: While the engine is idle, a register write with reg_sel=0 and bit 24 set (go) starts descriptor fetching at the pointer register. The four descriptor words are read at byte offsets 0, 4, 8 and 12 from the descriptor address, which is 16-byte aligned. A memory request holds its address until mem_ack.
- R2: If the control word read at offset 0 has bit 31 (ownership) clear, the engine sends no bytes, writes nothing, and idles. The pointer register still points at that descriptor, so the next go fetches it again.
- R3: The frame length is bits 31:16 of the word at offset 4, and the buffer start is the byte address at offset 8. Byte address a is taken from memory word a/4, bits 8*(a mod 4)+7 down to 8*(a mod 4). Bytes go out in ascending address order. tx_data holds while tx_valid is high and tx_ready is low, and tx_last marks the final byte.
- R4: When control bit 18 (pad) is set and the length is below MIN_FRAME (60), the frame is extended with zero bytes up to MIN_FRAME bytes. When bit 18 is clear, or the length is at least MIN_FRAME, exactly the stated length is sent.
- R5: After a frame, the control word is written back to offset 0 with the following fields:
  - bit 31 cleared;
  - bits 16:15 set to the error code, where 00 means success;
  - bits 3:0 set to the number of retries used;
  - all other bits unchanged.
  desc_done pulses for one cycle when the write is acknowledged.
- R6: irq pulses together with desc_done exactly when control bit 22 of that descriptor is set.
- R7: After the write-back, a non-zero next pointer (offset 12) becomes the current pointer and is fetched. A zero next pointer ends the chain and the engine idles.
- R8: A mac_done pulse with mac_ok=0 after the final byte makes the engine resend the whole frame from its first byte. The retry count is reported in the status word.
- R9: If RETRY_MAX (15) retries have already been used and the next attempt also fails, the descriptor is closed with error code 11 and a retry count of 15, and the chain continues.
- R10: A register write with reg_sel=0 and bits 31 and 15 both set (halt) sends the engine to idle on the next edge. The engine drops tx_valid and mem_req and does not write the descriptor back. Halt wins over go.
- R11: A pointer write (reg_sel=1) is taken only while idle. A pointer write or a go that arrives while the engine is busy has no effect.
- R12: During reset, tx_valid, mem_req, desc_done and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = command register, 1 = pointer register |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the 32-bit word accessed |
| mem_wdata | output | 32 | Write data (status word) |
| mem_ack | input | 1 | Access complete, read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame attempt |
| tx_ready | input | 1 | Stream sink accepts the byte |
| mac_done | input | 1 | Attempt result strobe |
| mac_ok | input | 1 | Attempt succeeded |
| desc_done | output | 1 | Descriptor closed |
| irq | output | 1 | Descriptor closed with interrupt requested |

## Verification
The bench builds the engine with its default parameters: a 32-bit address, MIN_FRAME of 60 and RETRY_MAX of 15. The full retry budget is therefore exercised. One frame is failed sixteen times to reach the error code and the saturated count. A second frame is failed twice to show a mid-count retry. A short padded frame, a frame longer than the minimum with pad set, and an unaligned buffer start together reach every byte lane and both sides of the padding threshold. The bench also covers stalls on tx_ready, an unowned descriptor, an abort in the middle of a frame, and commands ignored while the engine is busy.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GET_CMD,
        ST_GET_LEN,
        ST_GET_BUF,
        ST_GET_NEXT,
        ST_SEND,
        ST_LOAD,
        ST_WAIT_MAC,
        ST_WRITE_BACK
    } tdma_state_e;

    // control/status word fields
    localparam int OWN_BIT  = 31;
    localparam int IRQ_BIT  = 22;
    localparam int PAD_BIT  = 18;
    localparam int ERR_LO   = 15;

    // command register fields
    localparam int GO_BIT   = 24;
    localparam int HALT_HI  = 31;
    localparam int HALT_LO  = 15;

    localparam logic [1:0] ERR_NONE  = 2'b00;
    localparam logic [1:0] ERR_RETRY = 2'b11;

endpackage

// File: rtl/tdma_frame_len.sv
module tdma_frame_len #(
    parameter int LW        = 16,
    parameter int MIN_FRAME = 60
) (
    input  logic [LW-1:0] len,
    input  logic          pad_en,
    output logic [LW-1:0] total
);
    localparam logic [LW-1:0] MIN_LEN = LW'(MIN_FRAME);

    always_comb begin
        if (pad_en && (len < MIN_LEN)) total = MIN_LEN;
        else                           total = len;
    end
endmodule

// File: rtl/tdma_lane_sel.sv
module tdma_lane_sel #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]          word,
    input  logic [$clog2(DW/8)-1:0] lane,
    input  logic                   in_frame,
    output logic [7:0]             byte_o
);
    localparam int LANES = DW / 8;

    logic [7:0] lane_byte [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_byte[g] = word[8*g +: 8];
    end

    // bytes past the stated length are pad bytes and read as zero
    assign byte_o = in_frame ? lane_byte[lane] : 8'h00;
endmodule

// File: rtl/tdma_retry_ctr.sv
module tdma_retry_ctr #(
    parameter int RETRY_MAX = 15,
    parameter int RW        = $clog2(RETRY_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [RW-1:0] count,
    output logic          at_max
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end

    assign at_max = (count == RW'(RETRY_MAX));
endmodule

// File: rtl/tdma_tx_engine.sv
module tdma_tx_engine
    import tdma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int MIN_FRAME = 60,
    parameter int RETRY_MAX = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    input  logic          mac_done,
    input  logic          mac_ok,
    output logic          desc_done,
    output logic          irq
);
    localparam int LW = 16;
    localparam int RW = $clog2(RETRY_MAX + 1);
    localparam int WA = AW - 2;

    tdma_state_e state, state_nx;

    logic [AW-1:0] cur_ptr;
    logic [31:0]   cmd_q;
    logic [LW-1:0] len_q;
    logic [AW-1:0] buf_q;
    logic [AW-1:0] nxt_q;
    logic [LW-1:0] idx;
    logic [31:0]   word_q;
    logic [WA-1:0] waddr_q;
    logic          wvalid;
    logic [1:0]    err_q;

    logic [LW-1:0] total;
    logic [AW-1:0] byte_addr;
    logic          in_frame;
    logic          need_word;
    logic          final_byte;
    logic [7:0]    lane_byte;
    logic [RW-1:0] retry_cnt;
    logic          retry_full;
    logic          retry_clr;
    logic          retry_inc;

    // command decode
    logic halt_cmd, go_cmd, ptr_wr;
    assign halt_cmd = reg_wr && !reg_sel && reg_wdata[HALT_HI] && reg_wdata[HALT_LO];
    assign go_cmd   = reg_wr && !reg_sel && reg_wdata[GO_BIT] && !halt_cmd;
    assign ptr_wr   = reg_wr && reg_sel && (state == ST_IDLE);

    // datapath helpers
    assign byte_addr  = buf_q + AW'(idx);
    assign in_frame   = (idx < len_q);
    assign need_word  = in_frame && !(wvalid && (waddr_q == byte_addr[AW-1:2]));
    assign final_byte = (idx == total - 1'b1);
    assign retry_clr  = (state == ST_GET_NEXT) && mem_ack;
    assign retry_inc  = (state == ST_WAIT_MAC) && mac_done && !mac_ok && !retry_full;

    tdma_frame_len #(.LW(LW), .MIN_FRAME(MIN_FRAME)) u_len (
        .len    (len_q),
        .pad_en (cmd_q[PAD_BIT]),
        .total  (total)
    );

    tdma_lane_sel #(.DW(32)) u_lane (
        .word     (word_q),
        .lane     (byte_addr[1:0]),
        .in_frame (in_frame),
        .byte_o   (lane_byte)
    );

    tdma_retry_ctr #(.RETRY_MAX(RETRY_MAX), .RW(RW)) u_retry (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (retry_clr),
        .inc    (retry_inc),
        .count  (retry_cnt),
        .at_max (retry_full)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (halt_cmd) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:       if (go_cmd) state_nx = ST_GET_CMD;
                ST_GET_CMD:    if (mem_ack) state_nx = mem_rdata[OWN_BIT] ? ST_GET_LEN : ST_IDLE;
                ST_GET_LEN:    if (mem_ack) state_nx = ST_GET_BUF;
                ST_GET_BUF:    if (mem_ack) state_nx = ST_GET_NEXT;
                ST_GET_NEXT:   if (mem_ack) state_nx = (total == '0) ? ST_WRITE_BACK : ST_SEND;
                ST_SEND: begin
                    if (need_word)                    state_nx = ST_LOAD;
                    else if (tx_ready && final_byte)  state_nx = ST_WAIT_MAC;
                end
                ST_LOAD:       if (mem_ack) state_nx = ST_SEND;
                ST_WAIT_MAC: begin
                    if (mac_done) state_nx = (mac_ok || retry_full) ? ST_WRITE_BACK : ST_SEND;
                end
                ST_WRITE_BACK: if (mem_ack) state_nx = (nxt_q == '0) ? ST_IDLE : ST_GET_CMD;
                default:       state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // descriptor and buffer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ptr <= '0;
            cmd_q   <= '0;
            len_q   <= '0;
            buf_q   <= '0;
            nxt_q   <= '0;
            idx     <= '0;
            word_q  <= '0;
            waddr_q <= '0;
            wvalid  <= 1'b0;
            err_q   <= ERR_NONE;
        end else begin
            if (ptr_wr) cur_ptr <= reg_wdata[AW-1:0];
            case (state)
                ST_GET_CMD: if (mem_ack) cmd_q <= mem_rdata;
                ST_GET_LEN: if (mem_ack) len_q <= mem_rdata[31:16];
                ST_GET_BUF: if (mem_ack) buf_q <= mem_rdata[AW-1:0];
                ST_GET_NEXT: begin
                    if (mem_ack) begin
                        nxt_q  <= mem_rdata[AW-1:0];
                        idx    <= '0;
                        wvalid <= 1'b0;
                        err_q  <= ERR_NONE;
                    end
                end
                ST_SEND: begin
                    if (!need_word && tx_ready) idx <= idx + 1'b1;
                end
                ST_LOAD: begin
                    if (mem_ack) begin
                        word_q  <= mem_rdata;
                        waddr_q <= byte_addr[AW-1:2];
                        wvalid  <= 1'b1;
                    end
                end
                ST_WAIT_MAC: begin
                    if (mac_done && !mac_ok) begin
                        if (retry_full) err_q <= ERR_RETRY;
                        else            idx   <= '0;
                    end
                end
                ST_WRITE_BACK: begin
                    if (mem_ack && (nxt_q != '0)) cur_ptr <= nxt_q;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_ptr;
        mem_wdata = cmd_q;
        tx_valid  = 1'b0;
        tx_data   = lane_byte;
        tx_last   = 1'b0;
        desc_done = 1'b0;
        irq       = 1'b0;
        mem_wdata[OWN_BIT]           = 1'b0;
        mem_wdata[ERR_LO+1:ERR_LO]   = err_q;
        mem_wdata[RW-1:0]            = retry_cnt;
        unique case (state)
            ST_IDLE: ;
            ST_GET_CMD: begin
                mem_req  = 1'b1;
            end
            ST_GET_LEN: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + AW'(4);
            end
            ST_GET_BUF: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + AW'(8);
            end
            ST_GET_NEXT: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + AW'(12);
            end
            ST_SEND: begin
                tx_valid = !need_word;
                tx_last  = !need_word && final_byte;
            end
            ST_LOAD: begin
                mem_req  = 1'b1;
                mem_addr = {byte_addr[AW-1:2], 2'b00};
            end
            ST_WAIT_MAC: ;
            ST_WRITE_BACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                desc_done = mem_ack;
                irq       = mem_ack && cmd_q[IRQ_BIT];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tdma_tx_chk.sv
module tdma_tx_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop_cmd,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          wb_own,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          irq,
    input logic          desc_done
);
    // R1: a pending memory access keeps its request and address
    assert_mem_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !stop_cmd) |=> (mem_req && $stable(mem_addr)));

    // R3: a stalled byte stays offered unchanged
    assert_stream_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !stop_cmd) |=> (tx_valid && $stable(tx_data)));

    // R3: streaming and memory traffic never overlap
    assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_valid, mem_req}));

    // R5: every write returns ownership to software
    assert_owner_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !wb_own);

    // R6: interrupt only with a completion
    assert_irq_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> desc_done);

    // R10: halt silences the engine on the next edge
    assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> (!tx_valid && !mem_req));
endmodule

bind tdma_tx_engine tdma_tx_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_cmd  (reg_wr && !reg_sel && reg_wdata[31] && reg_wdata[15]),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .wb_own    (mem_wdata[31]),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .irq       (irq),
    .desc_done (desc_done)
);

// File: tb/tdma_tx_engine_tb.sv
`timescale 1ns/1ps
module tdma_tx_engine_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          tx_valid, tx_last;
    logic [7:0]    tx_data;
    logic          tx_ready = 1'b1;
    logic          mac_done = 1'b0;
    logic          mac_ok = 1'b1;
    logic          desc_done, irq;

    always #5 clk = ~clk;

    tdma_tx_engine #(.AW(AW), .MIN_FRAME(60), .RETRY_MAX(15)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .mac_done(mac_done), .mac_ok(mac_ok),
        .desc_done(desc_done), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R3";

    // ---------------- memory model ----------------
    logic [31:0] mem [1024];
    int          wr_cnt = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_hist [64];

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[11:2]] = mem_wdata;
                wr_cnt = wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[11:2]];
                rd_hist[rd_cnt[5:0]] = mem_addr;
                rd_cnt = rd_cnt + 1;
            end
        end
    end

    // ---------------- stream sink driver ----------------
    bit stall_mode = 0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 tx_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    // ---------------- scoreboard / monitor ----------------
    logic [8:0] exp_q [$];
    int done_cnt = 0, irq_cnt = 0, byte_cnt = 0;
    int stat_cnt = 0, fail_until = 0;
    bit stat_pend = 0;

    always @(negedge clk) begin
        if (stat_pend) begin
            mac_done = 1'b1;
            mac_ok   = (stat_cnt >= fail_until);
            stat_cnt = stat_cnt + 1;
            stat_pend = 0;
        end else begin
            mac_done = 1'b0;
        end
        if (rst_n) begin
            if (desc_done) done_cnt++;
            if (irq)       irq_cnt++;
            if (tx_valid && tx_ready) begin
                byte_cnt++;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL %s: unexpected byte %02h last=%0b, expected none", cur_req, tx_data, tx_last);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    if ({tx_last, tx_data} !== e) begin
                        errors++;
                        $display("FAIL %s: byte got last=%0b data=%02h, expected last=%0b data=%02h",
                                 cur_req, tx_last, tx_data, e[8], e[7:0]);
                    end
                end
                if (tx_last) stat_pend = 1;
            end
        end
    end

    // ---------------- watchdog ----------------
    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: run hung, got cycle %0d expected below 100000", cyc);
            report();
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [7:0] pat(int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic put_byte(int a, logic [7:0] v);
        mem[a >> 2][8*(a % 4) +: 8] = v;
    endtask

    task automatic fill_buf(int b, int n);
        for (int i = 0; i < n; i++) put_byte(b + i, pat(b + i));
    endtask

    task automatic put_desc(int d, logic [31:0] cmd, int len, int b, int nxt);
        mem[d >> 2]       = cmd;
        mem[(d >> 2) + 1] = 32'(len) << 16;
        mem[(d >> 2) + 2] = 32'(b);
        mem[(d >> 2) + 3] = 32'(nxt);
    endtask

    task automatic push_frame(int b, int len, bit pad, int times);
        int tot;
        tot = (pad && len < 60) ? 60 : len;
        for (int t = 0; t < times; t++)
            for (int i = 0; i < tot; i++)
                exp_q.push_back({(i == tot - 1), (i < len) ? pat(b + i) : 8'h00});
    endtask

    function automatic logic [31:0] wb_word(logic [31:0] cmd, logic [1:0] err, int rc);
        return (cmd & ~32'h8001_800F) | (32'(err) << 15) | 32'(rc);
    endfunction

    task automatic reg_write(bit sel, logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    endtask

    task automatic wait_done(int target);
        while (!(done_cnt >= target && exp_q.size() == 0)) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s got %08h expected %08h", req, what, got, exp);
        end
    endtask

    task automatic check_word(int a, logic [31:0] exp, string req);
        check(mem[a >> 2] === exp, req, "descriptor word", mem[a >> 2], exp);
    endtask

    // ---------------- test sequence ----------------
    initial begin
        int d0, i0, w0, b0, r0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;

        // R12: reset state
        repeat (3) @(negedge clk);
        check(!tx_valid, "R12", "tx_valid in reset", 32'(tx_valid), 0);
        check(!mem_req,  "R12", "mem_req in reset",  32'(mem_req),  0);
        check(!irq && !desc_done, "R12", "irq/desc_done in reset", 32'({irq, desc_done}), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1 R3 R5 R6: single unaligned descriptor with interrupt
        cur_req = "R3";
        fill_buf(32'h801, 8);
        put_desc(32'h100, 32'h8043_0000, 8, 32'h801, 0);
        push_frame(32'h801, 8, 0, 1);
        reg_write(1, 32'h100);
        r0 = rd_cnt;
        reg_write(0, 32'h0100_0000);
        wait_done(1);
        check(rd_hist[r0[5:0]] === 32'h100, "R1", "first fetch address", rd_hist[r0[5:0]], 32'h100);
        check(rd_hist[(r0 + 1) % 64] === 32'h104, "R1", "length fetch address", rd_hist[(r0 + 1) % 64], 32'h104);
        check_word(32'h100, wb_word(32'h8043_0000, 2'b00, 0), "R5");
        check(irq_cnt == 1, "R6", "irq count", 32'(irq_cnt), 1);
        check(done_cnt == 1, "R5", "done count", 32'(done_cnt), 1);

        // R4 R7: chain of three with stalls, short padded, unpadded, long padded
        cur_req = "R4";
        stall_mode = 1;
        fill_buf(32'h840, 5);  fill_buf(32'h880, 3);  fill_buf(32'h8C0, 61);
        put_desc(32'h140, 32'h8007_0000, 5,  32'h840, 32'h180);
        put_desc(32'h180, 32'h8003_0000, 3,  32'h880, 32'h1C0);
        put_desc(32'h1C0, 32'h8007_0000, 61, 32'h8C0, 0);
        push_frame(32'h840, 5, 1, 1);
        push_frame(32'h880, 3, 0, 1);
        push_frame(32'h8C0, 61, 1, 1);
        b0 = byte_cnt;
        reg_write(1, 32'h140);
        reg_write(0, 32'h0100_0000);
        wait_done(4);
        stall_mode = 0;
        check(byte_cnt - b0 == 124, "R4", "bytes in padded chain", 32'(byte_cnt - b0), 124);
        check_word(32'h140, wb_word(32'h8007_0000, 2'b00, 0), "R7");
        check_word(32'h180, wb_word(32'h8003_0000, 2'b00, 0), "R7");
        check_word(32'h1C0, wb_word(32'h8007_0000, 2'b00, 0), "R7");
        check(irq_cnt == 1, "R6", "irq without request", 32'(irq_cnt), 1);

        // R2: unowned descriptor stops the engine
        cur_req = "R2";
        fill_buf(32'h940, 4);
        put_desc(32'h200, 32'h0043_0000, 4, 32'h940, 0);
        reg_write(1, 32'h200);
        w0 = wr_cnt; b0 = byte_cnt; d0 = done_cnt;
        reg_write(0, 32'h0100_0000);
        repeat (60) @(negedge clk);
        check(byte_cnt == b0, "R2", "bytes sent for unowned", 32'(byte_cnt - b0), 0);
        check(wr_cnt == w0, "R2", "writes for unowned", 32'(wr_cnt - w0), 0);
        check(done_cnt == d0, "R2", "done for unowned", 32'(done_cnt - d0), 0);
        mem[32'h200 >> 2] = 32'h8043_0000;
        push_frame(32'h940, 4, 0, 1);
        reg_write(0, 32'h0100_0000);
        wait_done(d0 + 1);
        check_word(32'h200, wb_word(32'h8043_0000, 2'b00, 0), "R2");
        check(irq_cnt == 2, "R6", "irq after refetch", 32'(irq_cnt), 2);

        // R8 R11: two failed attempts, commands while busy ignored
        cur_req = "R8";
        fill_buf(32'h960, 6);
        put_desc(32'h240, 32'h8003_0000, 6, 32'h960, 0);
        push_frame(32'h960, 6, 0, 3);
        fail_until = stat_cnt + 2;
        reg_write(1, 32'h240);
        d0 = done_cnt;
        reg_write(0, 32'h0100_0000);
        repeat (3) @(negedge clk);
        reg_write(1, 32'h280);
        reg_write(0, 32'h0100_0000);
        wait_done(d0 + 1);
        check_word(32'h240, wb_word(32'h8003_0000, 2'b00, 2), "R8");
        check(done_cnt == d0 + 1, "R11", "done count with busy go", 32'(done_cnt - d0), 1);
        r0 = rd_cnt; b0 = byte_cnt;
        reg_write(0, 32'h0100_0000);
        repeat (30) @(negedge clk);
        check(rd_hist[r0[5:0]] === 32'h240, "R11", "fetch after busy ptr write", rd_hist[r0[5:0]], 32'h240);
        check(byte_cnt == b0, "R11", "bytes after refetch of closed desc", 32'(byte_cnt - b0), 0);

        // R9: retry limit exhausted, chain continues
        cur_req = "R9";
        fill_buf(32'h980, 4); fill_buf(32'h990, 1);
        put_desc(32'h280, 32'h8043_0000, 4, 32'h980, 32'h2C0);
        put_desc(32'h2C0, 32'h8003_0000, 1, 32'h990, 0);
        push_frame(32'h980, 4, 0, 16);
        push_frame(32'h990, 1, 0, 1);
        fail_until = stat_cnt + 16;
        reg_write(1, 32'h280);
        d0 = done_cnt; i0 = irq_cnt;
        reg_write(0, 32'h0100_0000);
        wait_done(d0 + 2);
        check_word(32'h280, wb_word(32'h8043_0000, 2'b11, 15), "R9");
        check_word(32'h2C0, wb_word(32'h8003_0000, 2'b00, 0), "R9");
        check(irq_cnt == i0 + 1, "R6", "irq on failed desc", 32'(irq_cnt - i0), 1);

        // R10: halt in the middle of a frame
        cur_req = "R10";
        fill_buf(32'hA00, 40);
        put_desc(32'h300, 32'h8003_0000, 40, 32'hA00, 0);
        push_frame(32'hA00, 40, 0, 1);
        reg_write(1, 32'h300);
        w0 = wr_cnt; d0 = done_cnt; b0 = byte_cnt;
        reg_write(0, 32'h0100_0000);
        while (byte_cnt < b0 + 10) @(negedge clk);
        reg_write(0, 32'h8000_8000 | 32'h0100_0000);
        @(negedge clk);
        check(!tx_valid && !mem_req, "R10", "activity after halt", 32'({tx_valid, mem_req}), 0);
        b0 = byte_cnt;
        repeat (30) @(negedge clk);
        exp_q.delete();
        check(byte_cnt == b0, "R10", "bytes after halt", 32'(byte_cnt - b0), 0);
        check(wr_cnt == w0, "R10", "write-back after halt", 32'(wr_cnt - w0), 0);
        check(done_cnt == d0, "R10", "done after halt", 32'(done_cnt - d0), 0);
        check_word(32'h300, 32'h8003_0000, "R10");

        report();
    end
endmodule